// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Manager

This block keeps a two-bank SDRAM refreshed and handles its two low-power states. A free-running interval counter adds one unit of refresh debt per period. While debt is non-zero the block asks the command arbiter for an auto-refresh. Each refresh the arbiter issues is acknowledged back and pays off one unit. When debt builds up past a threshold the request is flagged urgent, so the arbiter can rank it above normal traffic.

A sleep request puts the memory into self-refresh once both banks report idle. On wake-up the block holds off all commands for the row-cycle time. It then drives a back-to-back train of auto-refreshes itself, because the row the device refreshed last is unknown. A power-down request drops the clock enable only when no refresh is owed. Power-down ends when the request falls or when a programmable cap expires, since the device does no refresh of its own in that state. A recovery wait follows every exit. While the block owns the command pins it raises `busHold`, and the arbiter must stay off the bus.

Top module: `sdr_refresh_pm`

## Requirements
- R1: Reset state: `cke`=1, command pins {csN,rasN,casN,weN}=4'b1111 (deselect), `refReq`=0, `refUrgent`=0, `busHold`=0.
- R2: Refresh debt grows by one every REF_INTERVAL clocks, counted from reset release. The first `refReq` appears after the REF_INTERVAL-th rising edge and not before.
- R3: A `refAck` pulse lowers the debt by one. It is ignored when the debt is zero. A tick and an acknowledge in the same cycle leave a non-zero debt unchanged. `refReq` is high exactly when the debt is non-zero and `busHold` is low.
- R4: The debt saturates at DEBT_MAX. `refUrgent` is high while the debt is at least URGENT_LEVEL and `busHold` is low.
- R5: Self-refresh is entered only when `sleepReq` is high and all bits of `bankIdle` are 1. The entry cycle drives pins 4'b0001 with `cke`=0. After that the pins are 4'b1111 and `cke` stays 0 while `sleepReq` stays high.
- R6: One edge after `sleepReq` is seen low, `cke` returns to 1 and the pins show NOP (4'b0111). The first auto-refresh (pins 4'b0001, `cke`=1) appears exactly `trcCycles` clocks after `cke` rises.
- R7: After self-refresh exit, exactly BURST_COUNT (default 1024) auto-refreshes are driven, spaced `trcCycles` clocks apart. `busHold` falls `trcCycles` clocks after the last one. Debt is cleared and the interval restarts, so `refReq` first returns REF_INTERVAL clocks after `busHold` falls.
- R8: Power-down is entered (`cke`=0, pins 4'b1111) on the edge where `pdReq` is high, `sleepReq` is low and the debt is zero. It is never entered while debt is owed.
- R9: Power-down ends on the edge where `pdReq` is seen low. `busHold` stays high for `tckaCycles` clocks after `cke` rises. `cke` is never low while `busHold` is low.
- R10: A power-down holds `cke` low for at most `pdMaxCycles` clocks, even while `pdReq` stays high.
- R11: While `sleepReq` is high, `pdReq` has no effect, even when the banks are not idle.
- R12: `refReq` and `refUrgent` are low while `busHold` is high. Debt keeps accruing during power-down and is requested after exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| bankIdle | input | NUM_BANKS | Per-bank idle status |
| sleepReq | input | 1 | Level request for self-refresh |
| pdReq | input | 1 | Level request for power-down |
| refAck | input | 1 | Arbiter issued one requested auto-refresh |
| trcCycles | input | TRC_W | Row-cycle time in clocks |
| tckaCycles | input | TCKA_W | Clock-enable recovery time in clocks |
| pdMaxCycles | input | PD_W | Longest allowed power-down in clocks |
| refReq | output | 1 | Auto-refresh owed |
| refUrgent | output | 1 | Debt at or above the urgent level |
| busHold | output | 1 | Block owns the command pins; arbiter must idle |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |

## Verification
All outputs come from registers or from the state register, so a stimulus applied before edge k shows up just after edge k. The bench changes inputs and samples outputs only at falling edges and counts rising edges since reset release. Each expected value is pinned to an exact edge number: the first debt tick at edge REF_INTERVAL, cap exit at entry plus `pdMaxCycles`, bus release at `cke` rise plus `tckaCycles`, and refresh spacing of `trcCycles`. The debt table is checked one row at a time at the sampled edge. The refresh train is checked by recording the edge of every auto-refresh it sees.

// File: rtl/sdr_rpm_pkg.sv
package sdr_rpm_pkg;

  // Command the block places on the memory pins for the next cycle.
  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_NOP   = 2'd1,
    CMD_REF   = 2'd2   // auto-refresh with cke high, self-refresh with cke low
  } cmd_e;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SELF   = 3'd1,
    ST_BURST  = 3'd2,
    ST_PDOWN  = 3'd3,
    ST_PDEXIT = 3'd4
  } pm_state_e;

  // Strobes from the sequencer to the counters and pin registers.
  typedef struct packed {
    logic debtHold;
    logic reqOpen;
    logic waitLoadTrc;
    logic waitLoadTcka;
    logic burstLoad;
    logic burstDec;
    logic pdTimerRun;
    logic ckeNext;
    cmd_e cmdSel;
  } pm_strobe_t;

  // {csN, rasN, casN, weN}
  function automatic logic [3:0] cmdPins(cmd_e c);
    case (c)
      CMD_NOP: return 4'b0111;
      CMD_REF: return 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/sdr_rpm_dp.sv
module sdr_rpm_dp
  import sdr_rpm_pkg::*;
#(
  parameter int REF_INTERVAL = 1560,
  parameter int BURST_COUNT  = 1024,
  parameter int DEBT_MAX     = 8,
  parameter int URGENT_LEVEL = 4,
  parameter int TRC_W        = 8,
  parameter int TCKA_W       = 4,
  parameter int PD_W         = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pm_strobe_t        stb,
  input  logic              refAck,
  input  logic [TRC_W-1:0]  trcCycles,
  input  logic [TCKA_W-1:0] tckaCycles,
  input  logic [PD_W-1:0]   pdMaxCycles,
  output logic              debtZero,
  output logic              waitZero,
  output logic              burstDone,
  output logic              pdCapHit,
  output logic              refReq,
  output logic              refUrgent,
  output logic              cke,
  output logic [3:0]        cmdPinsQ
);

  localparam int IV_W    = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam int DEBT_W  = $clog2(DEBT_MAX + 1);
  localparam int BURST_W = $clog2(BURST_COUNT + 1);
  localparam int WAIT_W  = (TRC_W > TCKA_W) ? TRC_W : TCKA_W;

  // ---------------- refresh interval ----------------
  logic [IV_W-1:0] ivCnt;
  logic            tick;

  assign tick = (ivCnt == IV_W'(REF_INTERVAL - 1)) && !stb.debtHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     ivCnt <= '0;
    else if (stb.debtHold || tick) ivCnt <= '0;
    else                           ivCnt <= ivCnt + 1'b1;
  end

  // ---------------- refresh debt ----------------
  logic [DEBT_W-1:0] debtCnt;
  logic [DEBT_W:0]   debtSum;
  logic              ackOk;

  assign ackOk = refAck && (debtCnt != '0);

  always_comb begin
    debtSum = {1'b0, debtCnt} + {{DEBT_W{1'b0}}, tick} - {{DEBT_W{1'b0}}, ackOk};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     debtCnt <= '0;
    else if (stb.debtHold)                         debtCnt <= '0;
    else if (debtSum > (DEBT_W+1)'(DEBT_MAX))      debtCnt <= DEBT_W'(DEBT_MAX);
    else                                           debtCnt <= debtSum[DEBT_W-1:0];
  end

  assign debtZero  = (debtCnt == '0);
  assign refReq    = stb.reqOpen && !debtZero;
  assign refUrgent = stb.reqOpen && (debtCnt >= DEBT_W'(URGENT_LEVEL));

  // ---------------- recovery wait ----------------
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitLoad;

  always_comb begin
    waitLoad = '0;
    if (stb.waitLoadTrc)
      waitLoad = (trcCycles == '0) ? '0 : WAIT_W'(trcCycles - 1'b1);
    else if (stb.waitLoadTcka)
      waitLoad = (tckaCycles == '0) ? '0 : WAIT_W'(tckaCycles - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                waitCnt <= '0;
    else if (stb.waitLoadTrc || stb.waitLoadTcka) waitCnt <= waitLoad;
    else if (waitCnt != '0)                   waitCnt <= waitCnt - 1'b1;
  end

  assign waitZero = (waitCnt == '0);

  // ---------------- post-wake refresh train ----------------
  logic [BURST_W-1:0] burstLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                burstLeft <= '0;
    else if (stb.burstLoad)                   burstLeft <= BURST_W'(BURST_COUNT);
    else if (stb.burstDec && burstLeft != '0) burstLeft <= burstLeft - 1'b1;
  end

  assign burstDone = (burstLeft == '0);

  // ---------------- power-down cap ----------------
  logic [PD_W-1:0] pdTimer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pdTimer <= '0;
    else if (!stb.pdTimerRun) pdTimer <= '0;
    else if (pdTimer != '1)   pdTimer <= pdTimer + 1'b1;
  end

  assign pdCapHit = ({1'b0, pdTimer} + (PD_W+1)'(1)) >= {1'b0, pdMaxCycles};

  // ---------------- pin registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke      <= 1'b1;
      cmdPinsQ <= 4'b1111;
    end else begin
      cke      <= stb.ckeNext;
      cmdPinsQ <= cmdPins(stb.cmdSel);
    end
  end

  // R4
  debt_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    debtCnt <= DEBT_W'(DEBT_MAX));

  // R7
  ar_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmdSel == CMD_REF && stb.ckeNext) |-> (waitCnt == '0));

endmodule

// File: rtl/sdr_rpm_ctrl.sv
module sdr_rpm_ctrl
  import sdr_rpm_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] bankIdle,
  input  logic                 sleepReq,
  input  logic                 pdReq,
  input  logic                 debtZero,
  input  logic                 waitZero,
  input  logic                 burstDone,
  input  logic                 pdCapHit,
  output pm_strobe_t           stb,
  output logic                 busHold
);

  pm_state_e state, nxt;

  always_comb begin
    stb         = '0;
    stb.ckeNext = 1'b1;
    stb.cmdSel  = CMD_DESEL;
    nxt         = state;
    case (state)
      ST_RUN: begin
        stb.reqOpen = 1'b1;
        if (sleepReq) begin
          // sleep outranks power-down; wait for every bank to go idle
          if (&bankIdle) begin
            nxt         = ST_SELF;
            stb.cmdSel  = CMD_REF;
            stb.ckeNext = 1'b0;
          end
        end else if (pdReq && debtZero) begin
          nxt         = ST_PDOWN;
          stb.ckeNext = 1'b0;
        end
      end
      ST_SELF: begin
        stb.debtHold = 1'b1;
        if (!sleepReq) begin
          nxt             = ST_BURST;
          stb.cmdSel      = CMD_NOP;
          stb.waitLoadTrc = 1'b1;
          stb.burstLoad   = 1'b1;
        end else begin
          stb.ckeNext = 1'b0;
        end
      end
      ST_BURST: begin
        stb.debtHold = 1'b1;
        if (waitZero) begin
          if (!burstDone) begin
            stb.cmdSel      = CMD_REF;
            stb.waitLoadTrc = 1'b1;
            stb.burstDec    = 1'b1;
          end else begin
            nxt = ST_RUN;
          end
        end else begin
          stb.cmdSel = CMD_NOP;
        end
      end
      ST_PDOWN: begin
        stb.pdTimerRun = 1'b1;
        if (!pdReq || pdCapHit) begin
          nxt              = ST_PDEXIT;
          stb.waitLoadTcka = 1'b1;
        end else begin
          stb.ckeNext = 1'b0;
        end
      end
      ST_PDEXIT: begin
        if (waitZero) nxt = ST_RUN;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nxt;
  end

  assign busHold = (state != ST_RUN);

  // R11
  sleep_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && sleepReq) |=> (state != ST_PDOWN));

endmodule

// File: rtl/sdr_refresh_pm.sv
module sdr_refresh_pm
  import sdr_rpm_pkg::*;
#(
  parameter int NUM_BANKS    = 2,
  parameter int REF_INTERVAL = 1560,
  parameter int BURST_COUNT  = 1024,
  parameter int DEBT_MAX     = 8,
  parameter int URGENT_LEVEL = 4,
  parameter int TRC_W        = 8,
  parameter int TCKA_W       = 4,
  parameter int PD_W         = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] bankIdle,
  input  logic                 sleepReq,
  input  logic                 pdReq,
  input  logic                 refAck,
  input  logic [TRC_W-1:0]     trcCycles,
  input  logic [TCKA_W-1:0]    tckaCycles,
  input  logic [PD_W-1:0]      pdMaxCycles,
  output logic                 refReq,
  output logic                 refUrgent,
  output logic                 busHold,
  output logic                 cke,
  output logic                 csN,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN
);

  pm_strobe_t stb;
  logic       debtZero, waitZero, burstDone, pdCapHit;
  logic [3:0] pinsQ;

  sdr_rpm_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bankIdle  (bankIdle),
    .sleepReq  (sleepReq),
    .pdReq     (pdReq),
    .debtZero  (debtZero),
    .waitZero  (waitZero),
    .burstDone (burstDone),
    .pdCapHit  (pdCapHit),
    .stb       (stb),
    .busHold   (busHold)
  );

  sdr_rpm_dp #(
    .REF_INTERVAL (REF_INTERVAL),
    .BURST_COUNT  (BURST_COUNT),
    .DEBT_MAX     (DEBT_MAX),
    .URGENT_LEVEL (URGENT_LEVEL),
    .TRC_W        (TRC_W),
    .TCKA_W       (TCKA_W),
    .PD_W         (PD_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .refAck      (refAck),
    .trcCycles   (trcCycles),
    .tckaCycles  (tckaCycles),
    .pdMaxCycles (pdMaxCycles),
    .debtZero    (debtZero),
    .waitZero    (waitZero),
    .burstDone   (burstDone),
    .pdCapHit    (pdCapHit),
    .refReq      (refReq),
    .refUrgent   (refUrgent),
    .cke         (cke),
    .cmdPinsQ    (pinsQ)
  );

  assign {csN, rasN, casN, weN} = pinsQ;

  // R5
  sr_entry_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cke) && pinsQ == 4'b0001) |-> (&$past(bankIdle)));

  // R12
  req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    busHold |-> (!refReq && !refUrgent));

  // R9
  cke_low_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> busHold);

endmodule

// File: tb/sdr_refresh_pm_tb.sv
module sdr_refresh_pm_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IV         = 40;
  localparam int TRC        = 3;
  localparam int TCKA       = 3;
  localparam int NVEC       = 17;

  logic        clk, rstN;
  logic [1:0]  bankIdle;
  logic        sleepReq, pdReq, refAck;
  logic [7:0]  trcCycles;
  logic [3:0]  tckaCycles;
  logic [15:0] pdMaxCycles;
  logic        refReq, refUrgent, busHold, cke, csN, rasN, casN, weN;
  logic [3:0]  pinsW;

  assign pinsW = {csN, rasN, casN, weN};

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  sdr_refresh_pm #(.REF_INTERVAL(IV)) u_dut (
    .clk(clk), .rstN(rstN), .bankIdle(bankIdle), .sleepReq(sleepReq),
    .pdReq(pdReq), .refAck(refAck), .trcCycles(trcCycles),
    .tckaCycles(tckaCycles), .pdMaxCycles(pdMaxCycles),
    .refReq(refReq), .refUrgent(refUrgent), .busHold(busHold), .cke(cke),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {edges[15:0], ack, expReq, expUrgent}; rows are cumulative from reset release
  localparam logic [18:0] VECS [0:NVEC-1] = '{
    {16'd39,  1'b0, 1'b0, 1'b0},  // R2 edge 39: nothing owed yet
    {16'd1,   1'b0, 1'b1, 1'b0},  // R2 edge 40: first tick
    {16'd1,   1'b1, 1'b0, 1'b0},  // R3 paid off
    {16'd3,   1'b1, 1'b0, 1'b0},  // R3 acks at zero ignored
    {16'd35,  1'b0, 1'b0, 1'b0},  // edge 79
    {16'd1,   1'b1, 1'b1, 1'b0},  // R3 edge 80: tick with ack at zero debt
    {16'd40,  1'b0, 1'b1, 1'b0},  // edge 120: debt 2
    {16'd1,   1'b1, 1'b1, 1'b0},  // debt 1
    {16'd38,  1'b0, 1'b1, 1'b0},  // edge 159
    {16'd1,   1'b1, 1'b1, 1'b0},  // R3 edge 160: tick and ack cancel
    {16'd1,   1'b1, 1'b0, 1'b0},  // R3 debt was exactly 1
    {16'd158, 1'b0, 1'b1, 1'b0},  // edge 319: debt 3
    {16'd1,   1'b0, 1'b1, 1'b1},  // R4 edge 320: debt 4 urgent
    {16'd200, 1'b0, 1'b1, 1'b1},  // R4 edge 520: saturated at 8
    {16'd4,   1'b1, 1'b1, 1'b1},  // R4 debt 4
    {16'd1,   1'b1, 1'b1, 1'b0},  // R4 debt 3 proves saturation
    {16'd3,   1'b1, 1'b0, 1'b0}   // R4 debt 0
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] idle, input logic slp, input logic pd,
                         input logic [15:0] pdMax);
    rstN = 1'b0; refAck = 1'b0;
    bankIdle = idle; sleepReq = slp; pdReq = pd; pdMaxCycles = pdMax;
    trcCycles = 8'(TRC); tckaCycles = 4'(TCKA);
    adv(2);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // -------- reset state and debt table --------
    doReset(2'b11, 1'b0, 1'b0, 16'd10);
    check("R1 cke", int'(cke), 1);
    check("R1 pins", int'(pinsW), 15);
    check("R1 refReq", int'(refReq), 0);
    check("R1 refUrgent", int'(refUrgent), 0);
    check("R1 busHold", int'(busHold), 0);
    for (int i = 0; i < NVEC; i++) begin
      refAck = VECS[i][2];
      adv(int'(VECS[i][18:3]));
      refAck = 1'b0;
      check($sformatf("R2/R3/R4 row%0d refReq", i), int'(refReq), int'(VECS[i][1]));
      check($sformatf("R4 row%0d refUrgent", i), int'(refUrgent), int'(VECS[i][0]));
    end

    // -------- power-down cap, recovery, voluntary exit --------
    doReset(2'b11, 1'b0, 1'b1, 16'd10);
    adv(1);
    check("R8 entry cke", int'(cke), 0);
    check("R8 entry pins", int'(pinsW), 15);
    check("R8 entry busHold", int'(busHold), 1);
    adv(9);
    check("R10 before cap cke", int'(cke), 0);
    adv(1);
    check("R10 cap exit cke", int'(cke), 1);
    adv(2);
    check("R9 recovery busHold", int'(busHold), 1);
    adv(1);
    check("R9 release busHold", int'(busHold), 0);
    adv(1);
    check("R8 re-entry cke", int'(cke), 0);
    adv(1);
    pdReq = 1'b0;
    adv(1);
    check("R9 exit on request cke", int'(cke), 1);
    adv(2);
    check("R9 recovery2 busHold", int'(busHold), 1);
    adv(1);
    check("R9 release2 busHold", int'(busHold), 0);

    // -------- debt accrual during power-down --------
    doReset(2'b11, 1'b0, 1'b1, 16'd100);
    adv(50);
    check("R12 gated refReq", int'(refReq), 0);
    check("R12 held busHold", int'(busHold), 1);
    adv(51);
    check("R10 long cap cke", int'(cke), 1);
    adv(3);
    check("R12 after exit busHold", int'(busHold), 0);
    check("R12 after exit refReq", int'(refReq), 1);
    adv(1);
    check("R8 owed no entry cke", int'(cke), 1);
    refAck = 1'b1;
    adv(1);
    check("R12 two owed refReq", int'(refReq), 1);
    adv(1);
    refAck = 1'b0;
    check("R8 still up cke", int'(cke), 1);
    check("R3 paid refReq", int'(refReq), 0);
    adv(1);
    check("R8 entry after payoff cke", int'(cke), 0);

    // -------- self-refresh, wake-up train --------
    doReset(2'b01, 1'b1, 1'b1, 16'd10);
    adv(3);
    check("R11 no power-down cke", int'(cke), 1);
    check("R5 banks busy busHold", int'(busHold), 0);
    bankIdle = 2'b11;
    adv(1);
    check("R5 entry pins", int'(pinsW), 1);
    check("R5 entry cke", int'(cke), 0);
    check("R5 entry busHold", int'(busHold), 1);
    adv(1);
    check("R5 hold pins", int'(pinsW), 15);
    check("R5 hold cke", int'(cke), 0);
    adv(5);
    check("R5 still asleep cke", int'(cke), 0);
    sleepReq = 1'b0; pdReq = 1'b0;
    adv(1);
    check("R6 wake cke", int'(cke), 1);
    check("R6 wake pins", int'(pinsW), 7);
    adv(2);
    check("R6 tRC gap pins", int'(pinsW), 7);
    adv(1);
    check("R6 first refresh pins", int'(pinsW), 1);
    check("R6 first refresh cke", int'(cke), 1);
    begin
      int edgeNo  = 14;
      int lastRef = 14;
      int nRef    = 1;
      int badGap  = 0;
      for (int g = 0; g < 5000 && busHold; g++) begin
        adv(1);
        edgeNo++;
        if (pinsW == 4'b0001 && cke) begin
          if (edgeNo - lastRef != TRC) badGap++;
          nRef++;
          lastRef = edgeNo;
        end
      end
      check("R7 refresh count", nRef, 1024);
      check("R7 spacing errors", badGap, 0);
      check("R7 release delay", edgeNo - lastRef, TRC);
    end
    adv(IV - 1);
    check("R7 interval restart refReq", int'(refReq), 0);
    adv(1);
    check("R7 first tick after wake refReq", int'(refReq), 1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule